// File: doc/BRIEF.md
# Shared-Pin Local Reset and NMI Steering

This block takes a single shared local-reset pin and a single shared non-maskable-interrupt pin and steers them to one of four processor cores, or to all four at once. A 3-bit select input picks the target, and an active-low enable pin gates the whole pin path. Each pin combination has its own meaning: assert reset, assert NMI, or release both. The block records that meaning in per-core sticky state. The pins arrive asynchronously. A two-flop synchroniser brings them into the clock domain, and a stability filter then accepts only a value that has held for two consecutive sampled clocks. This keeps select-code changes from glitching into a wrong core.

Each core has a small state machine with four states: `CS_CLEAR` (no flag set), `CS_RESET` (reset flag only), `CS_NMI` (NMI flag only) and `CS_BOTH` (both flags). An accepted reset command moves the core CLEAR→RESET or NMI→BOTH. An accepted NMI command moves it CLEAR→NMI or RESET→BOTH. An accepted release command moves any state back to CLEAR. A core that is not targeted, or that receives no accepted command, keeps its state.

Per-core software requests and watchdog requests are ORed into the outputs. The reset output is a registered level. The NMI output is a registered single-cycle pulse, produced when that core's combined NMI request rises.

Top module: `lrst_nmi_steer`

## Requirements
- R1: While `pin_en_n` is 1, the reset and NMI pins have no effect, and no core's state or output changes because of them.
- R2: When `pin_en_n` is 0 and `pin_lrst_n` is 0, the selected core(s) enter local reset, whatever level `pin_nmi_n` has.
- R3: Select values 0, 1, 2 and 3 target core 0, 1, 2 and 3. Any select value with bit 2 set (4 to 7) targets all four cores.
- R4: When `pin_en_n` is 0, `pin_lrst_n` is 1 and `pin_nmi_n` is 0, the NMI flag of each selected core is set. `core_nmi[i]` pulses high for exactly one cycle when the combined NMI request of core i rises. A repeated NMI command to a core whose flag is already set gives no new pulse.
- R5: When `pin_en_n` is 0 and both `pin_lrst_n` and `pin_nmi_n` are 1, both flags of each selected core are cleared. Cores that are not selected keep their flags.
- R6: The flags stay set after the enable pin returns high, until a release command clears them.
- R7: `core_lrst[i]` is 1 whenever the reset flag of core i, `sw_lrst_req[i]` or `wdt_lrst_req[i]` is set.
- R8: A rise of `sw_nmi_req[i]` or `wdt_nmi_req[i]` produces an NMI pulse on core i, provided its combined NMI request was low before.
- R9: A pin pattern that is present for only one sampled clock is ignored.
- R10: After `rst_n` is released, every core is out of local reset with no NMI pending, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pin_sel | input | 3 | Core-select pin code (bit 2 selects broadcast) |
| pin_lrst_n | input | 1 | Shared local-reset pin, active low |
| pin_nmi_n | input | 1 | Shared NMI pin, active low |
| pin_en_n | input | 1 | Pin-path enable, active low |
| sw_lrst_req | input | 4 | Software local-reset request, one bit per core |
| sw_nmi_req | input | 4 | Software NMI request, one bit per core |
| wdt_lrst_req | input | 4 | Watchdog local-reset request, one bit per core |
| wdt_nmi_req | input | 4 | Watchdog NMI request, one bit per core |
| core_lrst | output | 4 | Local reset level to each core |
| core_nmi | output | 4 | Single-cycle NMI pulse to each core |

## Verification
A pin change that is first sampled at clock edge E0 reaches the outputs at edge E4. The path counts two synchroniser flops, the stability register, the core state register and the output register. A software or watchdog request reaches the outputs at the first edge after it changes. The bench holds each stimulus for ten cycles before it queues the expected result, so every result has settled well before it is compared. The monitor compares reset levels at a falling edge. It also counts NMI pulses per core over the whole window, which catches a missing pulse, an extra pulse and a pulse that is too long.

// File: rtl/lrn_pkg.sv
package lrn_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_RESET   = 2'd1,
        CMD_NMI     = 2'd2,
        CMD_RELEASE = 2'd3
    } pin_cmd_e;

    typedef enum logic [1:0] {
        CS_CLEAR = 2'd0,
        CS_RESET = 2'd1,
        CS_NMI   = 2'd2,
        CS_BOTH  = 2'd3
    } core_state_e;

endpackage

// File: rtl/lrn_pin_filter.sv
module lrn_pin_filter #(
    parameter int          WIDTH       = 6,
    parameter int          SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] data_o,
    output logic             stable_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] chain_q [SYNC_STAGES];
    logic [WIDTH-1:0] held_q;

    // synchroniser chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
                chain_q[s] <= IDLE_VAL;
            end
        end else begin
            chain_q[0] <= raw_i;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // previous synchronised value, used for the stability test
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= IDLE_VAL;
        end else begin
            held_q <= chain_q[LAST];
        end
    end

    assign data_o   = held_q;
    assign stable_o = (chain_q[LAST] == held_q);

endmodule

// File: rtl/lrn_cmd_decode.sv
module lrn_cmd_decode
    import lrn_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int NUM_CORES = 4
) (
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 lrst_n_i,
    input  logic                 nmi_n_i,
    input  logic                 en_n_i,
    input  logic                 stable_i,
    output pin_cmd_e             cmd_o,
    output logic [NUM_CORES-1:0] target_o
);

    localparam int IDX_W = SEL_W - 1;

    logic             broadcast;
    logic [IDX_W-1:0] core_idx;

    assign broadcast = sel_i[SEL_W-1];
    assign core_idx  = sel_i[IDX_W-1:0];

    always_comb begin
        cmd_o    = CMD_NONE;
        target_o = '0;
        if (stable_i && !en_n_i) begin
            if (!lrst_n_i) begin
                cmd_o = CMD_RESET;
            end else if (!nmi_n_i) begin
                cmd_o = CMD_NMI;
            end else begin
                cmd_o = CMD_RELEASE;
            end
            if (broadcast) begin
                target_o = '1;
            end else begin
                target_o = NUM_CORES'(1) << core_idx;
            end
        end
    end

endmodule

// File: rtl/lrn_core_fsm.sv
module lrn_core_fsm
    import lrn_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cmd_e cmd_i,
    input  logic     hit_i,
    input  logic     sw_lrst_i,
    input  logic     sw_nmi_i,
    input  logic     wdt_lrst_i,
    input  logic     wdt_nmi_i,
    output logic     lrst_o,
    output logic     nmi_o
);

    core_state_e state_q;
    core_state_e state_d;
    logic        do_rst;
    logic        do_nmi;
    logic        do_rel;
    logic        flag_rst;
    logic        flag_nmi;
    logic        nmi_lvl;
    logic        nmi_lvl_q;

    assign do_rst = hit_i && (cmd_i == CMD_RESET);
    assign do_nmi = hit_i && (cmd_i == CMD_NMI);
    assign do_rel = hit_i && (cmd_i == CMD_RELEASE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_CLEAR: begin
                if (do_rst)      state_d = CS_RESET;
                else if (do_nmi) state_d = CS_NMI;
            end
            CS_RESET: begin
                if (do_nmi)      state_d = CS_BOTH;
                else if (do_rel) state_d = CS_CLEAR;
            end
            CS_NMI: begin
                if (do_rst)      state_d = CS_BOTH;
                else if (do_rel) state_d = CS_CLEAR;
            end
            CS_BOTH: begin
                if (do_rel)      state_d = CS_CLEAR;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_rst = (state_q == CS_RESET) || (state_q == CS_BOTH);
    assign flag_nmi = (state_q == CS_NMI)   || (state_q == CS_BOTH);
    assign nmi_lvl  = flag_nmi || sw_nmi_i || wdt_nmi_i;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lrst_o    <= 1'b0;
            nmi_o     <= 1'b0;
            nmi_lvl_q <= 1'b0;
        end else begin
            lrst_o    <= flag_rst || sw_lrst_i || wdt_lrst_i;
            nmi_o     <= nmi_lvl && !nmi_lvl_q;
            nmi_lvl_q <= nmi_lvl;
        end
    end

endmodule

// File: rtl/lrst_nmi_steer.sv
module lrst_nmi_steer
    import lrn_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_CORES  = 2 ** (SEL_W - 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     pin_sel,
    input  logic                 pin_lrst_n,
    input  logic                 pin_nmi_n,
    input  logic                 pin_en_n,
    input  logic [NUM_CORES-1:0] sw_lrst_req,
    input  logic [NUM_CORES-1:0] sw_nmi_req,
    input  logic [NUM_CORES-1:0] wdt_lrst_req,
    input  logic [NUM_CORES-1:0] wdt_nmi_req,
    output logic [NUM_CORES-1:0] core_lrst,
    output logic [NUM_CORES-1:0] core_nmi
);

    localparam int PIN_W = SEL_W + 3;
    localparam logic [PIN_W-1:0] PIN_IDLE = {{SEL_W{1'b0}}, 3'b111};

    logic [PIN_W-1:0]     pins_raw;
    logic [PIN_W-1:0]     pins_flt;
    logic                 pins_stable;
    pin_cmd_e             cmd;
    logic [NUM_CORES-1:0] target;

    assign pins_raw = {pin_sel, pin_en_n, pin_lrst_n, pin_nmi_n};

    lrn_pin_filter #(
        .WIDTH       (PIN_W),
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_VAL    (PIN_IDLE)
    ) filter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (pins_raw),
        .data_o   (pins_flt),
        .stable_o (pins_stable)
    );

    lrn_cmd_decode #(
        .SEL_W     (SEL_W),
        .NUM_CORES (NUM_CORES)
    ) decode_i (
        .sel_i    (pins_flt[PIN_W-1:3]),
        .en_n_i   (pins_flt[2]),
        .lrst_n_i (pins_flt[1]),
        .nmi_n_i  (pins_flt[0]),
        .stable_i (pins_stable),
        .cmd_o    (cmd),
        .target_o (target)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        lrn_core_fsm core_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_i      (cmd),
            .hit_i      (target[c]),
            .sw_lrst_i  (sw_lrst_req[c]),
            .sw_nmi_i   (sw_nmi_req[c]),
            .wdt_lrst_i (wdt_lrst_req[c]),
            .wdt_nmi_i  (wdt_nmi_req[c]),
            .lrst_o     (core_lrst[c]),
            .nmi_o      (core_nmi[c])
        );
    end

endmodule

// File: rtl/lrst_nmi_steer_chk.sv
module lrst_nmi_steer_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pin_en_n,
    input logic [NUM_CORES-1:0] sw_lrst_req,
    input logic [NUM_CORES-1:0] wdt_lrst_req,
    input logic [NUM_CORES-1:0] core_lrst,
    input logic [NUM_CORES-1:0] core_nmi
);

    logic [3:0] en_off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_off_cnt <= '0;
        end else if (!pin_en_n) begin
            en_off_cnt <= '0;
        end else if (en_off_cnt != 4'hF) begin
            en_off_cnt <= en_off_cnt + 4'd1;
        end
    end

    // R1: with the pin path disabled long enough, pins cannot move reset outputs
    p_pins_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_off_cnt >= 4'd6 && sw_lrst_req == '0 && wdt_lrst_req == '0 &&
         $past(sw_lrst_req) == '0 && $past(wdt_lrst_req) == '0)
        |=> $stable(core_lrst));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R4: an NMI pulse lasts exactly one cycle
        p_nmi_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            core_nmi[c] |=> !core_nmi[c]);
        // R7: software reset request forces the core reset on the next cycle
        p_sw_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            sw_lrst_req[c] |=> core_lrst[c]);
        // R7: watchdog reset request forces the core reset on the next cycle
        p_wdt_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            wdt_lrst_req[c] |=> core_lrst[c]);
    end

endmodule

bind lrst_nmi_steer lrst_nmi_steer_chk #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_en_n     (pin_en_n),
    .sw_lrst_req  (sw_lrst_req),
    .wdt_lrst_req (wdt_lrst_req),
    .core_lrst    (core_lrst),
    .core_nmi     (core_nmi)
);

// File: tb/lrst_nmi_steer_tb_top.sv
module lrst_nmi_steer_tb_top;

    localparam int NC   = 4;
    localparam int HOLD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    pin_sel = 3'd0;
    logic          pin_lrst_n = 1'b1;
    logic          pin_nmi_n = 1'b1;
    logic          pin_en_n = 1'b1;
    logic [NC-1:0] sw_lrst_req = '0;
    logic [NC-1:0] sw_nmi_req = '0;
    logic [NC-1:0] wdt_lrst_req = '0;
    logic [NC-1:0] wdt_nmi_req = '0;
    logic [NC-1:0] core_lrst;
    logic [NC-1:0] core_nmi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // expected model
    logic [NC-1:0] m_rst = '0;
    logic [NC-1:0] m_nmi = '0;
    logic [NC-1:0] m_nmi_lvl = '0;
    logic [NC-1:0] m_pulse = '0;

    logic [NC-1:0] q_lrst [$];
    logic [NC-1:0] q_pulse [$];
    string         q_tag [$];
    int            pulse_cnt [NC];

    always #2.5 clk = ~clk;

    lrst_nmi_steer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_sel      (pin_sel),
        .pin_lrst_n   (pin_lrst_n),
        .pin_nmi_n    (pin_nmi_n),
        .pin_en_n     (pin_en_n),
        .sw_lrst_req  (sw_lrst_req),
        .sw_nmi_req   (sw_nmi_req),
        .wdt_lrst_req (wdt_lrst_req),
        .wdt_nmi_req  (wdt_nmi_req),
        .core_lrst    (core_lrst),
        .core_nmi     (core_nmi)
    );

    // update the NMI-level model and note which cores must see a pulse
    task automatic model_nmi_edges();
        logic [NC-1:0] lvl;
        lvl       = m_nmi | sw_nmi_req | wdt_nmi_req;
        m_pulse   = m_pulse | (lvl & ~m_nmi_lvl);
        m_nmi_lvl = lvl;
    endtask

    task automatic push_expect(input string tag);
        repeat (HOLD) @(negedge clk);
        #1;
        q_lrst.push_back(m_rst | sw_lrst_req | wdt_lrst_req);
        q_pulse.push_back(m_pulse);
        q_tag.push_back(tag);
        m_pulse = '0;
        @(negedge clk);
    endtask

    task automatic drive_pins(input logic [2:0] sel, input logic en_n,
                              input logic lrst_n, input logic nmi_n,
                              input string tag);
        logic [NC-1:0] tgt;
        @(negedge clk);
        pin_sel    = sel;
        pin_en_n   = en_n;
        pin_lrst_n = lrst_n;
        pin_nmi_n  = nmi_n;
        if (!en_n) begin
            tgt = sel[2] ? '1 : (NC'(1) << sel[1:0]);
            for (int c = 0; c < NC; c++) begin
                if (tgt[c]) begin
                    if (!lrst_n)     m_rst[c] = 1'b1;
                    else if (!nmi_n) m_nmi[c] = 1'b1;
                    else begin
                        m_rst[c] = 1'b0;
                        m_nmi[c] = 1'b0;
                    end
                end
            end
        end
        model_nmi_edges();
        push_expect(tag);
    endtask

    task automatic drive_req(input logic [NC-1:0] swr, input logic [NC-1:0] swn,
                             input logic [NC-1:0] wdr, input logic [NC-1:0] wdn,
                             input string tag);
        @(negedge clk);
        sw_lrst_req  = swr;
        sw_nmi_req   = swn;
        wdt_lrst_req = wdr;
        wdt_nmi_req  = wdn;
        model_nmi_edges();
        push_expect(tag);
    endtask

    // monitor: counts pulses and compares queued expectations
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NC; c++) begin
                if (core_nmi[c]) pulse_cnt[c]++;
            end
            if (q_tag.size() > 0) begin
                logic [NC-1:0] e_l;
                logic [NC-1:0] e_p;
                string         t;
                e_l = q_lrst.pop_front();
                e_p = q_pulse.pop_front();
                t   = q_tag.pop_front();
                checks++;
                if (core_lrst !== e_l) begin
                    failures++;
                    $display("FAIL %s core_lrst act=%b exp=%b", t, core_lrst, e_l);
                end
                for (int c = 0; c < NC; c++) begin
                    checks++;
                    if (pulse_cnt[c] != int'(e_p[c])) begin
                        failures++;
                        $display("FAIL %s core%0d nmi pulses act=%0d exp=%0d",
                                 t, c, pulse_cnt[c], int'(e_p[c]));
                    end
                    pulse_cnt[c] = 0;
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) pulse_cnt[c] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        @(negedge clk);
        checks++;
        if (core_lrst !== '0 || core_nmi !== '0) begin
            failures++;
            $display("FAIL R10 after reset act=%b/%b exp=0000/0000", core_lrst, core_nmi);
        end
        push_expect("R10 idle after reset");
        // R1: disabled pin path ignores a broadcast reset code
        drive_pins(3'b100, 1'b1, 1'b0, 1'b0, "R1 reset code while disabled");
        drive_pins(3'b000, 1'b1, 1'b1, 1'b0, "R1 nmi code while disabled");
        // R2/R3: reset core 2, NMI pin low does not matter
        drive_pins(3'b010, 1'b0, 1'b0, 1'b0, "R2 R3 reset core2 with nmi low");
        // R4: NMI to core 0
        drive_pins(3'b000, 1'b0, 1'b1, 1'b0, "R4 nmi core0");
        // R6: disable, then re-issue NMI to core0: sticky, no new pulse
        drive_pins(3'b000, 1'b1, 1'b1, 1'b1, "R6 flags held while disabled");
        drive_pins(3'b000, 1'b0, 1'b1, 1'b0, "R4 repeated nmi no pulse");
        // R5/R3: broadcast release
        drive_pins(3'b110, 1'b0, 1'b1, 1'b1, "R5 R3 release all");
        // R3: broadcast reset with select 5
        drive_pins(3'b101, 1'b0, 1'b0, 1'b1, "R3 reset all");
        // R5: release core 1 only
        drive_pins(3'b001, 1'b0, 1'b1, 1'b1, "R5 release core1 only");
        // R3/R4: broadcast NMI
        drive_pins(3'b111, 1'b0, 1'b1, 1'b0, "R3 R4 nmi all");
        drive_pins(3'b011, 1'b0, 1'b1, 1'b1, "R5 release core3");
        // R9: one-sample glitch onto a reset code for core 0
        @(negedge clk);
        pin_sel    = 3'b000;
        pin_lrst_n = 1'b0;
        @(negedge clk);
        pin_sel    = 3'b011;
        pin_lrst_n = 1'b1;
        push_expect("R9 glitch rejected");
        drive_pins(3'b100, 1'b0, 1'b1, 1'b1, "R5 release all again");
        drive_pins(3'b100, 1'b1, 1'b1, 1'b1, "R1 disable path");
        // R7: software and watchdog resets
        drive_req(4'b1000, 4'b0000, 4'b0010, 4'b0000, "R7 sw core3 wdt core1 reset");
        drive_req(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R7 requests removed");
        // R8: software and watchdog NMIs
        drive_req(4'b0000, 4'b0100, 4'b0001, 4'b0000, "R8 sw nmi core2");
        drive_req(4'b0000, 4'b0100, 4'b0001, 4'b0001, "R8 wdt nmi core0");
        drive_req(4'b0000, 4'b0000, 4'b0000, 4'b0000, "R8 nmi requests removed");
        // R8: pin NMI flag already set hides a software NMI rise
        drive_pins(3'b001, 1'b0, 1'b1, 1'b0, "R4 nmi core1");
        drive_req(4'b0000, 4'b0010, 4'b0000, 4'b0000, "R8 sw nmi masked by flag");
        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired act=running exp=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule